// File: doc/BRIEF.md
# Dual-Clock FIFO with Coordinated Flush on Either Reset

This block carries data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. The producer pushes a word whenever the full flag is low. The consumer pops a word whenever the empty flag is low and receives it on the following read-clock edge. Pointers cross between the domains in Gray code through two-stage synchronisers.

Each domain has its own active-low reset. Both resets have the same effect: either one empties the whole queue. A reset in one domain travels into the other domain as a four-phase request/acknowledge exchange, with two synchroniser stages in each direction. Both sides hold their pointers at zero and keep their flags in the blocked state until the exchange has finished. The two pointers therefore always restart together, and a word written before the reset can never be read out afterwards.

Top module: `cdc_flush_fifo`

## Requirements
- R1: After both resets are released and the clock-crossing handshake completes, `wrFull` is 0, `rdEmpty` is 1 and `rdData` is 0.
- R2: Words come out in the order they were pushed. A pop accepted on a read-clock edge presents its word on `rdData` from that edge onward, and `rdData` does not change in any cycle with no accepted pop.
- R3: After DEPTH pushes with no pops, `wrFull` is 1. A push while `wrFull` is 1 stores nothing and leaves the write pointer unchanged, so the next DEPTH pops return exactly the DEPTH earlier words and the FIFO is then empty.
- R4: A pop while `rdEmpty` is 1 is ignored. `rdData` and the read pointer keep their values, and the next pushed word is the next word popped.
- R5: A reset applied to the write side only empties the FIFO. After recovery `rdEmpty` is 1 and `wrFull` is 0. The first word pushed afterwards is the first word popped, and no older word appears.
- R6: A reset applied to the read side only empties the FIFO, including one that was full. After recovery `wrFull` is 0, `rdEmpty` is 1 and `rdData` is 0. The first word pushed afterwards is the first word popped.
- R7: While either reset input is low, or its effect is still crossing to the other domain, `wrFull` and `rdEmpty` are both held at 1. In particular, `wrFull` is 1 at every write-clock edge with `wrRstN` low, and `rdEmpty` is 1 at every read-clock edge with `rdRstN` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Write-domain reset, active low, asynchronous assert |
| wrPush | input | 1 | Push request, accepted when `wrFull` is 0 |
| wrData | input | DATA_W | Word to push |
| wrFull | output | 1 | No space, or a flush is in progress |
| rdClk | input | 1 | Read-domain clock |
| rdRstN | input | 1 | Read-domain reset, active low, asynchronous assert |
| rdPop | input | 1 | Pop request, accepted when `rdEmpty` is 0 |
| rdData | output | DATA_W | Registered output word |
| rdEmpty | output | 1 | Nothing to read, or a flush is in progress |

## Verification
Two cases are exercised in the same time window.

In the first, a push and a pop land together at the empty boundary. The bench pushes a stream of words with gaps while a concurrent reader pops each word as soon as `rdEmpty` falls. The stream is judged by the order and values of the popped words.

In the second, a one-sided reset arrives while the opposite side still holds data: a full queue under a read reset, and a part-filled queue under a write reset. Each case is judged by the blocked flags during the reset, by the empty and not-full state after recovery, and by the fact that the first word popped afterwards is the new word and not an older one.

// File: rtl/fifo_xfer_pkg.sv
`timescale 1ns/1ps
package fifo_xfer_pkg;
  // Per-cycle transfer strobes from the control logic to the storage.
  typedef struct packed {
    logic wrEn;  // write-clock strobe: store wrData at the write address
    logic rdEn;  // read-clock strobe: load the word at the read address
  } xfer_strobe_t;
endpackage

// File: rtl/fifo_sync2.sv
`timescale 1ns/1ps
// Two-stage synchroniser with an asynchronous clear to zero.
module fifo_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
// Pointer, flag and reset-coordination logic for both clock domains.
module fifo_ctrl
  import fifo_xfer_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic         wrClk,
  input  logic         wrRstN,
  input  logic         wrPush,
  output logic         wrFull,
  input  logic         rdClk,
  input  logic         rdRstN,
  input  logic         rdPop,
  output logic         rdEmpty,
  output xfer_strobe_t strobe,
  output logic [AW:0]  wrPtr,
  output logic [AW:0]  rdPtr,
  output logic         rdRst
);
  localparam int PW = AW + 1;
  // Inverting the two top Gray bits of the read pointer gives the
  // write pointer value that means "full".
  localparam logic [PW-1:0] FULL_FLIP = PW'(3) << (AW - 1);

  // Local resets: asserted asynchronously, released on the local clock.
  logic wrRstQ, rdRstQ, wrRst;
  fifo_sync2 #(.W(1)) u_wrRstSync (.clk(wrClk), .clr(!wrRstN), .d(1'b1), .q(wrRstQ));
  fifo_sync2 #(.W(1)) u_rdRstSync (.clk(rdClk), .clr(!rdRstN), .d(1'b1), .q(rdRstQ));
  assign wrRst = !wrRstQ;
  assign rdRst = !rdRstQ;

  // Four-phase flush handshake, one request per domain.
  logic wrReq, rdReq;
  logic wrReqInRd, rdReqInWr, wrAck, rdAck;
  fifo_sync2 #(.W(1)) u_wrReqX (.clk(rdClk), .clr(rdRst), .d(wrReq),     .q(wrReqInRd));
  fifo_sync2 #(.W(1)) u_wrAckX (.clk(wrClk), .clr(wrRst), .d(wrReqInRd), .q(wrAck));
  fifo_sync2 #(.W(1)) u_rdReqX (.clk(wrClk), .clr(wrRst), .d(rdReq),     .q(rdReqInWr));
  fifo_sync2 #(.W(1)) u_rdAckX (.clk(rdClk), .clr(rdRst), .d(rdReqInWr), .q(rdAck));

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst)      wrReq <= 1'b1;
    else if (wrAck) wrReq <= 1'b0;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)      rdReq <= 1'b1;
    else if (rdAck) rdReq <= 1'b0;
  end

  logic wrHold, rdHold;
  assign wrHold = wrRst | wrReq | wrAck | rdReqInWr;
  assign rdHold = rdRst | rdReq | rdAck | wrReqInRd;

  // Pointers: binary for addressing, registered Gray for crossing.
  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] wrBinNext, rdBinNext;
  logic [PW-1:0] rdGrayInWr, wrGrayInRd;
  logic          wrEn, rdEn;

  fifo_sync2 #(.W(PW)) u_rdPtrX (.clk(wrClk), .clr(wrRst), .d(rdGray), .q(rdGrayInWr));
  fifo_sync2 #(.W(PW)) u_wrPtrX (.clk(rdClk), .clr(rdRst), .d(wrGray), .q(wrGrayInRd));

  assign wrFull    = wrHold | (wrGray == (rdGrayInWr ^ FULL_FLIP));
  assign rdEmpty   = rdHold | (rdGray == wrGrayInRd);
  assign wrEn      = wrPush & !wrFull;
  assign rdEn      = rdPop & !rdEmpty;
  assign wrBinNext = wrBin + PW'(1);
  assign rdBinNext = rdBin + PW'(1);

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrHold) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrEn) begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdHold) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdEn) begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assign strobe.wrEn = wrEn;
  assign strobe.rdEn = rdEn;
  assign wrPtr       = wrBin;
  assign rdPtr       = rdBin;
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
// Storage array with a registered read port.
module fifo_store
  import fifo_xfer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rdRst,
  input  xfer_strobe_t  strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrEn) cells[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)            rdData <= '0;
    else if (strobe.rdEn) rdData <= cells[rdAddr];
  end
endmodule

// File: rtl/cdc_flush_fifo.sv
`timescale 1ns/1ps
module cdc_flush_fifo
  import fifo_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrPush,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdPop,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);
  localparam int AW = $clog2(DEPTH);

  xfer_strobe_t strobe;
  logic [AW:0]  wrPtr;
  logic [AW:0]  rdPtr;
  logic         rdRst;

  fifo_ctrl #(.AW(AW)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrPush(wrPush), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdPop(rdPop),   .rdEmpty(rdEmpty),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .rdRst(rdRst)
  );

  fifo_store #(.DW(DATA_W), .AW(AW)) u_store (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(rdRst), .strobe(strobe),
    .wrAddr(wrPtr[AW-1:0]), .wrData(wrData),
    .rdAddr(rdPtr[AW-1:0]), .rdData(rdData)
  );
endmodule

// File: rtl/fifo_flush_chk.sv
`timescale 1ns/1ps
module fifo_flush_chk #(
  parameter int DW = 32,
  parameter int PW = 5
) (
  input logic          wrClk,
  input logic          wrRstN,
  input logic          wrFull,
  input logic [PW-1:0] wrPtr,
  input logic          rdClk,
  input logic          rdRstN,
  input logic          rdPop,
  input logic          rdEmpty,
  input logic [PW-1:0] rdPtr,
  input logic [DW-1:0] rdData
);
  // R7
  always @(posedge wrClk) begin
    if (!wrRstN) wr_reset_full_chk: assert (wrFull);
  end

  // R7
  always @(posedge rdClk) begin
    if (!rdRstN) rd_reset_empty_chk: assert (rdEmpty);
  end

  // R3
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull |=> ((wrPtr == $past(wrPtr)) || (wrPtr == '0)));

  // R4
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEmpty |=> ((rdPtr == $past(rdPtr)) || (rdPtr == '0)));

  // R2
  rd_data_hold_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(rdPop && !rdEmpty) |=> $stable(rdData));
endmodule

bind cdc_flush_fifo fifo_flush_chk #(.DW(DATA_W), .PW(AW + 1)) u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .wrFull(wrFull), .wrPtr(wrPtr),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdPop(rdPop), .rdEmpty(rdEmpty),
  .rdPtr(rdPtr), .rdData(rdData)
);

// File: tb/cdc_flush_fifo_bench.sv
`timescale 1ns/1ps
module cdc_flush_fifo_bench;
  localparam int DW    = 32;
  localparam int DEPTH = 16;

  logic          wrClk = 1'b0;
  logic          rdClk = 1'b0;
  logic          wrRstN = 1'b1;
  logic          rdRstN = 1'b1;
  logic          wrPush = 1'b0;
  logic          rdPop  = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          wrFull, rdEmpty;
  logic [DW-1:0] rdData;

  int vecs = 0;
  int errs = 0;

  always #10 wrClk = ~wrClk;  // 50 MHz write clock
  always #17 rdClk = ~rdClk;  // unrelated read clock

  cdc_flush_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_cdc_flush_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrPush(wrPush), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdPop(rdPop), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] w);
    @(negedge wrClk); wrPush = 1'b1; wrData = w;
    @(negedge wrClk); wrPush = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] w);
    @(negedge rdClk); rdPop = 1'b1;
    @(negedge rdClk); rdPop = 1'b0;
    w = rdData;
  endtask

  task automatic settle();
    repeat (40) @(negedge rdClk);
  endtask

  task automatic t_reset();
    #1 wrRstN = 1'b0; rdRstN = 1'b0;
    repeat (4) @(negedge wrClk);
    check("R7 wrFull in reset", DW'(wrFull), 1);
    check("R7 rdEmpty in reset", DW'(rdEmpty), 1);
    wrRstN = 1'b1; rdRstN = 1'b1;
    settle();
    check("R1 wrFull", DW'(wrFull), 0);
    check("R1 rdEmpty", DW'(rdEmpty), 1);
    check("R1 rdData", rdData, 0);
  endtask

  task automatic t_order();
    logic [DW-1:0] got;
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + DW'(i));
    settle();
    check("R2 not empty", DW'(rdEmpty), 0);
    for (int i = 0; i < 5; i++) begin
      pop(got);
      check("R2 order", got, 32'hA000_0000 + DW'(i));
    end
    repeat (3) @(negedge rdClk);
    check("R2 hold without pop", rdData, 32'hA000_0004);
    check("R2 empty after drain", DW'(rdEmpty), 1);
  endtask

  task automatic t_full();
    logic [DW-1:0] got;
    for (int i = 0; i < DEPTH; i++) push(32'hB000_0000 + DW'(i));
    settle();
    check("R3 full", DW'(wrFull), 1);
    push(32'hDEAD_BEEF);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop(got);
      check("R3 contents", got, 32'hB000_0000 + DW'(i));
    end
    settle();
    check("R3 empty, extra word dropped", DW'(rdEmpty), 1);
    check("R3 not full", DW'(wrFull), 0);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] prev, got;
    settle();
    prev = rdData;
    pop(got);
    check("R4 rdData kept", got, prev);
    push(32'h00C0_FFEE);
    settle();
    pop(got);
    check("R4 next word", got, 32'h00C0_FFEE);
  endtask

  task automatic t_wr_reset();
    logic [DW-1:0] got;
    for (int i = 0; i < 4; i++) push(32'hC000_0000 + DW'(i));
    settle();
    @(negedge wrClk); wrRstN = 1'b0;
    repeat (6) @(negedge wrClk);
    check("R7 wrFull in write reset", DW'(wrFull), 1);
    check("R5 rdEmpty in write reset", DW'(rdEmpty), 1);
    wrRstN = 1'b1;
    settle();
    check("R5 rdEmpty after", DW'(rdEmpty), 1);
    check("R5 wrFull after", DW'(wrFull), 0);
    push(32'h5555_0001);
    settle();
    pop(got);
    check("R5 no stale word", got, 32'h5555_0001);
    settle();
    check("R5 empty again", DW'(rdEmpty), 1);
  endtask

  task automatic t_rd_reset();
    logic [DW-1:0] got;
    for (int i = 0; i < DEPTH; i++) push(32'hD000_0000 + DW'(i));
    settle();
    check("R6 full before", DW'(wrFull), 1);
    @(negedge rdClk); rdRstN = 1'b0;
    repeat (6) @(negedge rdClk);
    check("R7 rdEmpty in read reset", DW'(rdEmpty), 1);
    check("R6 wrFull in read reset", DW'(wrFull), 1);
    rdRstN = 1'b1;
    settle();
    check("R6 wrFull after", DW'(wrFull), 0);
    check("R6 rdEmpty after", DW'(rdEmpty), 1);
    check("R6 rdData cleared", rdData, 0);
    push(32'h6666_0001);
    settle();
    pop(got);
    check("R6 no stale word", got, 32'h6666_0001);
  endtask

  task automatic t_overlap();
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          push(32'hE000_0000 + DW'(i));
          repeat (i % 3) @(negedge wrClk);
        end
      end
      begin
        logic [DW-1:0] got;
        for (int i = 0; i < 8; i++) begin
          @(negedge rdClk);
          while (rdEmpty) @(negedge rdClk);
          pop(got);
          check("R2 overlapped stream", got, 32'hE000_0000 + DW'(i));
        end
      end
    join
    settle();
    check("R2 empty after stream", DW'(rdEmpty), 1);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_underflow();
    t_wr_reset();
    t_rd_reset();
    t_overlap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #3_000_000;
    errs++;
    $display("FAIL watchdog (R1..all): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule